// File: doc/BRIEF.md
# Multiplexed Host Register Bus Slave

This block sits behind a host bridge that drives an 8-bit shared address/data bus through general-purpose pins. The host reaches any register in two transactions on the same data lines: first it writes the register number with the address/data select line high, then it performs a data read or write with the select line low. Each strobe is answered by an active-low ready handshake, so the host can run the bus at any speed relative to the slave clock.

Behind the handshake sits a small register file: an interrupt control register with an acknowledge-on-read pending flag, two bus-control registers (one of which carries the stream output enables and the per-channel tuner resets), address byte pairs and data ports for a card window and for a packet-filter table, two stream clock dividers and a read-only revision. The data ports do not store anything themselves; they issue one-cycle read or write strobes to the downstream blocks and return the data those blocks present. The block exposes split data-in, data-out and output-enable signals so that the pad ring builds the tristate buffer.

Top module: `hbus_regslave`

## Requirements
- R1: After reset rdy_n and irq_n are high, data_oe is low, and every control output (bus_ctrl, bus_ctrl2, ts_en, tuner_rst, both dividers, both address pairs, every port strobe) is zero.
- R2: A write with ad_sel high latches data_i[3:0] as the register number; each later transaction with ad_sel low reads or writes that register, and the number stays latched across any count of data transactions.
- R3: With two synchroniser stages, rdy_n falls on the third rising clock edge after cs_n and a strobe (wr_n or rd_n) go low; only one access is performed per strobe.
- R4: rdy_n returns high on the third rising edge after cs_n goes high or both strobes go high, and no new access starts until it has.
- R5: data_oe is high only while cs_n and rd_n are both low during a data read handshake; it drops as soon as either pin goes high and is never high for writes or address cycles.
- R6: Registers 0x1 (bus_ctrl2), 0x4/0x5 (card address low/high), 0x7 (bus_ctrl), 0x8/0x9 (filter address low/high), 0xC and 0xD (stream dividers A and B) read back the last value written and drive their outputs; cam_addr is {0x5,0x4} and pid_addr is {0x9,0x8}.
- R7: Register 0xF reads the REVISION parameter and writes to it have no effect.
- R8: Addresses 0x2, 0x3, 0xB and 0xE read 0x00 and writes to them change no register.
- R9: ts_en equals bus_ctrl2 bits 5:4 and tuner_rst equals bus_ctrl2 bits 3:2.
- R10: A pulse on irq_evt sets a pending flag; irq_n is low while the flag is set and interrupt control bits 6 and 2 are both set (value 0x44 enables); register 0x0 reads back its bits 7:1 with the pending flag in bit 0, and that read clears the flag.
- R11: A data write to 0x6 (card port) or 0xA (filter port) pulses cam_wr or pid_wr for one cycle with port_wdata holding the written byte; a data read from them pulses cam_rd or pid_rd for one cycle and returns cam_rdata or pid_rdata.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slave clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| ad_sel | input | 1 | High: address cycle, low: data cycle |
| wr_n | input | 1 | Write strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| data_i | input | DW | Bus data from the pad |
| data_o | output | DW | Bus data to the pad |
| data_oe | output | 1 | Pad output enable |
| rdy_n | output | 1 | Ready handshake, active low |
| irq_evt | input | 1 | Interrupt event pulse from the card logic |
| irq_n | output | 1 | Interrupt request, active low |
| cam_rdata | input | DW | Read data from the card window |
| pid_rdata | input | DW | Read data from the filter table |
| cam_addr | output | 2*DW | Card window address |
| pid_addr | output | 2*DW | Filter table address |
| port_wdata | output | DW | Write data for both data ports |
| cam_wr | output | 1 | Card port write strobe |
| cam_rd | output | 1 | Card port read strobe |
| pid_wr | output | 1 | Filter port write strobe |
| pid_rd | output | 1 | Filter port read strobe |
| bus_ctrl | output | DW | Bus control register |
| bus_ctrl2 | output | DW | Bus control 2 register |
| ts_en | output | 2 | Stream output enables |
| tuner_rst | output | 2 | Tuner reset controls, active high |
| div_a | output | DW | Stream A clock divider |
| div_b | output | DW | Stream B clock divider |

## Verification
The assertions watch every cycle that ready only falls after a strobe was seen through the synchroniser, that it releases once the host lets go, that the output enable never appears outside a handshake, that at most one port strobe fires at a time, that bus_ctrl2 moves only on a write to its address and that the interrupt pin never falls without a pending flag. What the register map actually holds, the fixed three-edge handshake latency, the acknowledge-on-read of the interrupt and the fact that unmapped and read-only writes leave every register untouched can only be shown by the bench's sweeps, which write every address with two value patterns and read all sixteen back against an arithmetic model.

// File: rtl/hbus_pkg.sv
package hbus_pkg;

  localparam int REG_AW = 4;

  // bits of the interrupt control register that must both be set to drive irq
  localparam int IRQ_EN_HI = 6;
  localparam int IRQ_EN_LO = 2;

  // bus_ctrl2 field positions
  localparam int TS_EN_LSB  = 4;
  localparam int TRST_LSB   = 2;

  typedef enum logic [REG_AW-1:0] {
    RA_IRQ  = 4'h0,
    RA_BC2  = 4'h1,
    RA_CAML = 4'h4,
    RA_CAMH = 4'h5,
    RA_CAMD = 4'h6,
    RA_BC   = 4'h7,
    RA_PIDL = 4'h8,
    RA_PIDH = 4'h9,
    RA_PIDD = 4'hA,
    RA_DIVA = 4'hC,
    RA_DIVB = 4'hD,
    RA_REV  = 4'hF
  } reg_addr_e;

  typedef enum logic {
    HS_IDLE = 1'b0,
    HS_BUSY = 1'b1
  } hs_state_e;

endpackage

// File: rtl/hbus_sync.sv
module hbus_sync #(
  parameter int WIDTH = 4,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  logic [STAGES-1:0][WIDTH-1:0] stage_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) stage_q[0] <= RST_VAL;
        else     stage_q[0] <= async_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) begin
          for (int s = 0; s < STAGES; s++) stage_q[s] <= RST_VAL;
        end else begin
          stage_q[0] <= async_i;
          for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/hbus_handshake.sv
module hbus_handshake
  import hbus_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_s_n,
  input  logic              ad_s,
  input  logic              wr_s_n,
  input  logic              rd_s_n,
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic [DW-1:0]     data_i,
  output logic              reg_wr_o,
  output logic              reg_rd_o,
  output logic [REG_AW-1:0] addr_o,
  output logic              rdy_n_o,
  output logic              data_oe_o
);

  hs_state_e         st_q;
  logic              rdy_n_q;
  logic              oe_q;
  logic [REG_AW-1:0] addr_q;

  logic strobe_seen;
  logic released;
  logic acc;
  logic acc_wr;

  assign strobe_seen = !cs_s_n && (!wr_s_n || !rd_s_n);
  assign released    = cs_s_n || (wr_s_n && rd_s_n);
  assign acc         = (st_q == HS_IDLE) && strobe_seen;
  assign acc_wr      = !wr_s_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= HS_IDLE;
      rdy_n_q <= 1'b1;
      oe_q    <= 1'b0;
      addr_q  <= '0;
    end else begin
      case (st_q)
        HS_IDLE: begin
          if (acc) begin
            st_q    <= HS_BUSY;
            rdy_n_q <= 1'b0;
            oe_q    <= !acc_wr && !ad_s;
            if (acc_wr && ad_s) addr_q <= data_i[REG_AW-1:0];
          end
        end
        HS_BUSY: begin
          if (released) begin
            st_q    <= HS_IDLE;
            rdy_n_q <= 1'b1;
            oe_q    <= 1'b0;
          end
        end
        default: st_q <= HS_IDLE;
      endcase
    end
  end

  assign reg_wr_o  = acc && acc_wr && !ad_s;
  assign reg_rd_o  = acc && !acc_wr && !ad_s;
  assign addr_o    = addr_q;
  assign rdy_n_o   = rdy_n_q;
  assign data_oe_o = oe_q && !cs_n && !rd_n;

  AST_RDY_AFTER_STROBE: assert property (@(posedge clk) disable iff (rst)
    $fell(rdy_n_o) |-> $past(strobe_seen)); // R3

  AST_RDY_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (!rdy_n_o && released) |=> rdy_n_o); // R4

  AST_OE_IN_HANDSHAKE: assert property (@(posedge clk) disable iff (rst)
    data_oe_o |-> !rdy_n_o); // R5

endmodule

// File: rtl/hbus_regfile.sv
module hbus_regfile
  import hbus_pkg::*;
#(
  parameter int DW = 8,
  parameter logic [DW-1:0] REVISION = 8'h3C
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic              irq_evt_i,
  input  logic [DW-1:0]     cam_rdata_i,
  input  logic [DW-1:0]     pid_rdata_i,
  output logic [DW-1:0]     rdata_o,
  output logic              irq_n_o,
  output logic [DW-1:0]     bc_o,
  output logic [DW-1:0]     bc2_o,
  output logic [2*DW-1:0]   cam_addr_o,
  output logic [2*DW-1:0]   pid_addr_o,
  output logic [DW-1:0]     div_a_o,
  output logic [DW-1:0]     div_b_o,
  output logic [DW-1:0]     port_wdata_o,
  output logic              cam_wr_o,
  output logic              cam_rd_o,
  output logic              pid_wr_o,
  output logic              pid_rd_o
);

  logic [DW-1:1] irq_ctrl_q;
  logic          pend_q;
  logic          irq_n_q;
  logic [DW-1:0] bc_q, bc2_q, caml_q, camh_q, pidl_q, pidh_q, diva_q, divb_q;
  logic [DW-1:0] rdata_q, port_wdata_q;
  logic          cam_wr_q, cam_rd_q, pid_wr_q, pid_rd_q;
  logic [DW-1:0] rd_mux;
  logic          irq_ack;

  assign irq_ack = rd_i && (addr_i == RA_IRQ);

  always_comb begin
    case (addr_i)
      RA_IRQ:  rd_mux = {irq_ctrl_q, pend_q};
      RA_BC2:  rd_mux = bc2_q;
      RA_CAML: rd_mux = caml_q;
      RA_CAMH: rd_mux = camh_q;
      RA_CAMD: rd_mux = cam_rdata_i;
      RA_BC:   rd_mux = bc_q;
      RA_PIDL: rd_mux = pidl_q;
      RA_PIDH: rd_mux = pidh_q;
      RA_PIDD: rd_mux = pid_rdata_i;
      RA_DIVA: rd_mux = diva_q;
      RA_DIVB: rd_mux = divb_q;
      RA_REV:  rd_mux = REVISION;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_ctrl_q <= '0;
      bc_q       <= '0;
      bc2_q      <= '0;
      caml_q     <= '0;
      camh_q     <= '0;
      pidl_q     <= '0;
      pidh_q     <= '0;
      diva_q     <= '0;
      divb_q     <= '0;
    end else if (wr_i) begin
      case (addr_i)
        RA_IRQ:  irq_ctrl_q <= wdata_i[DW-1:1];
        RA_BC2:  bc2_q      <= wdata_i;
        RA_CAML: caml_q     <= wdata_i;
        RA_CAMH: camh_q     <= wdata_i;
        RA_BC:   bc_q       <= wdata_i;
        RA_PIDL: pidl_q     <= wdata_i;
        RA_PIDH: pidh_q     <= wdata_i;
        RA_DIVA: diva_q     <= wdata_i;
        RA_DIVB: divb_q     <= wdata_i;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q      <= '0;
      port_wdata_q <= '0;
      cam_wr_q     <= 1'b0;
      cam_rd_q     <= 1'b0;
      pid_wr_q     <= 1'b0;
      pid_rd_q     <= 1'b0;
    end else begin
      if (rd_i) rdata_q <= rd_mux;
      if (wr_i) port_wdata_q <= wdata_i;
      cam_wr_q <= wr_i && (addr_i == RA_CAMD);
      cam_rd_q <= rd_i && (addr_i == RA_CAMD);
      pid_wr_q <= wr_i && (addr_i == RA_PIDD);
      pid_rd_q <= rd_i && (addr_i == RA_PIDD);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q  <= 1'b0;
      irq_n_q <= 1'b1;
    end else begin
      pend_q  <= irq_evt_i || (pend_q && !irq_ack);
      irq_n_q <= !(pend_q && irq_ctrl_q[IRQ_EN_HI] && irq_ctrl_q[IRQ_EN_LO]);
    end
  end

  assign rdata_o      = rdata_q;
  assign irq_n_o      = irq_n_q;
  assign bc_o         = bc_q;
  assign bc2_o        = bc2_q;
  assign cam_addr_o   = {camh_q, caml_q};
  assign pid_addr_o   = {pidh_q, pidl_q};
  assign div_a_o      = diva_q;
  assign div_b_o      = divb_q;
  assign port_wdata_o = port_wdata_q;
  assign cam_wr_o     = cam_wr_q;
  assign cam_rd_o     = cam_rd_q;
  assign pid_wr_o     = pid_wr_q;
  assign pid_rd_o     = pid_rd_q;

  AST_PORT_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0({cam_wr_o, cam_rd_o, pid_wr_o, pid_rd_o})); // R11

  AST_BC2_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(wr_i && addr_i == RA_BC2) |=> $stable(bc2_o)); // R6

  AST_IRQ_NEEDS_PENDING: assert property (@(posedge clk) disable iff (rst)
    $fell(irq_n_o) |-> $past(pend_q)); // R10

  AST_NO_WR_RD_TOGETHER: assert property (@(posedge clk) disable iff (rst)
    !(wr_i && rd_i)); // R3

endmodule

// File: rtl/hbus_regslave.sv
module hbus_regslave
  import hbus_pkg::*;
#(
  parameter int DW = 8,
  parameter int SYNC_STAGES = 2,
  parameter logic [DW-1:0] REVISION = 8'h3C
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cs_n,
  input  logic            ad_sel,
  input  logic            wr_n,
  input  logic            rd_n,
  input  logic [DW-1:0]   data_i,
  output logic [DW-1:0]   data_o,
  output logic            data_oe,
  output logic            rdy_n,
  input  logic            irq_evt,
  output logic            irq_n,
  input  logic [DW-1:0]   cam_rdata,
  input  logic [DW-1:0]   pid_rdata,
  output logic [2*DW-1:0] cam_addr,
  output logic [2*DW-1:0] pid_addr,
  output logic [DW-1:0]   port_wdata,
  output logic            cam_wr,
  output logic            cam_rd,
  output logic            pid_wr,
  output logic            pid_rd,
  output logic [DW-1:0]   bus_ctrl,
  output logic [DW-1:0]   bus_ctrl2,
  output logic [1:0]      ts_en,
  output logic [1:0]      tuner_rst,
  output logic [DW-1:0]   div_a,
  output logic [DW-1:0]   div_b
);

  localparam int NCTL = 4;
  // order {cs_n, ad_sel, wr_n, rd_n}; strobes idle high
  localparam logic [NCTL-1:0] CTL_IDLE = 4'b1011;

  logic [NCTL-1:0]   ctl_s;
  logic              reg_wr, reg_rd;
  logic [REG_AW-1:0] reg_addr;

  hbus_sync #(
    .WIDTH  (NCTL),
    .STAGES (SYNC_STAGES),
    .RST_VAL(CTL_IDLE)
  ) u_sync (
    .clk    (clk),
    .rst    (rst),
    .async_i({cs_n, ad_sel, wr_n, rd_n}),
    .sync_o (ctl_s)
  );

  hbus_handshake #(.DW(DW)) u_hs (
    .clk      (clk),
    .rst      (rst),
    .cs_s_n   (ctl_s[3]),
    .ad_s     (ctl_s[2]),
    .wr_s_n   (ctl_s[1]),
    .rd_s_n   (ctl_s[0]),
    .cs_n     (cs_n),
    .rd_n     (rd_n),
    .data_i   (data_i),
    .reg_wr_o (reg_wr),
    .reg_rd_o (reg_rd),
    .addr_o   (reg_addr),
    .rdy_n_o  (rdy_n),
    .data_oe_o(data_oe)
  );

  hbus_regfile #(
    .DW      (DW),
    .REVISION(REVISION)
  ) u_regs (
    .clk         (clk),
    .rst         (rst),
    .wr_i        (reg_wr),
    .rd_i        (reg_rd),
    .addr_i      (reg_addr),
    .wdata_i     (data_i),
    .irq_evt_i   (irq_evt),
    .cam_rdata_i (cam_rdata),
    .pid_rdata_i (pid_rdata),
    .rdata_o     (data_o),
    .irq_n_o     (irq_n),
    .bc_o        (bus_ctrl),
    .bc2_o       (bus_ctrl2),
    .cam_addr_o  (cam_addr),
    .pid_addr_o  (pid_addr),
    .div_a_o     (div_a),
    .div_b_o     (div_b),
    .port_wdata_o(port_wdata),
    .cam_wr_o    (cam_wr),
    .cam_rd_o    (cam_rd),
    .pid_wr_o    (pid_wr),
    .pid_rd_o    (pid_rd)
  );

  assign ts_en     = bus_ctrl2[TS_EN_LSB +: 2];
  assign tuner_rst = bus_ctrl2[TRST_LSB +: 2];

endmodule

// File: tb/tb_hbus_regslave.sv
`timescale 1ns/1ps
module tb_hbus_regslave;

  localparam int DW = 8;
  localparam logic [7:0] REV = 8'h3C;
  localparam logic [7:0] CAM_RD_VAL = 8'hC3;
  localparam logic [7:0] PID_RD_VAL = 8'h96;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1, ad_sel = 1'b0, wr_n = 1'b1, rd_n = 1'b1;
  logic [7:0] data_i = '0;
  logic [7:0] data_o;
  logic data_oe, rdy_n, irq_n;
  logic irq_evt = 1'b0;
  logic [7:0] cam_rdata = CAM_RD_VAL, pid_rdata = PID_RD_VAL;
  logic [15:0] cam_addr, pid_addr;
  logic [7:0] port_wdata, bus_ctrl, bus_ctrl2, div_a, div_b;
  logic cam_wr, cam_rd, pid_wr, pid_rd;
  logic [1:0] ts_en, tuner_rst;

  always #2 clk = ~clk;

  hbus_regslave #(.DW(DW), .SYNC_STAGES(2), .REVISION(REV)) dut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .ad_sel(ad_sel), .wr_n(wr_n), .rd_n(rd_n),
    .data_i(data_i), .data_o(data_o), .data_oe(data_oe), .rdy_n(rdy_n),
    .irq_evt(irq_evt), .irq_n(irq_n), .cam_rdata(cam_rdata), .pid_rdata(pid_rdata),
    .cam_addr(cam_addr), .pid_addr(pid_addr), .port_wdata(port_wdata),
    .cam_wr(cam_wr), .cam_rd(cam_rd), .pid_wr(pid_wr), .pid_rd(pid_rd),
    .bus_ctrl(bus_ctrl), .bus_ctrl2(bus_ctrl2), .ts_en(ts_en), .tuner_rst(tuner_rst),
    .div_a(div_a), .div_b(div_b)
  );

  int n_chk = 0;
  int n_fail = 0;

  // downstream strobe monitor, sampled mid-cycle
  int cnt_cam_wr = 0, cnt_cam_rd = 0, cnt_pid_wr = 0, cnt_pid_rd = 0;
  logic [7:0] last_cam_w = '0, last_pid_w = '0;
  always @(negedge clk) begin
    if (cam_wr) begin cnt_cam_wr++; last_cam_w = port_wdata; end
    if (pid_wr) begin cnt_pid_wr++; last_pid_w = port_wdata; end
    if (cam_rd) cnt_cam_rd++;
    if (pid_rd) cnt_pid_rd++;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // results of the last transaction
  int         last_lat, last_rel;
  logic [7:0] last_dout;
  logic       last_oe, oe_after;

  task automatic access(input logic ad, input logic wr, input logic [7:0] din);
    @(negedge clk);
    data_i = din;
    ad_sel = ad;
    cs_n   = 1'b0;
    if (wr) wr_n = 1'b0; else rd_n = 1'b0;
    last_lat = 0;
    while (rdy_n && last_lat < 50) begin
      @(negedge clk);
      last_lat++;
    end
    last_dout = data_o;
    last_oe   = data_oe;
    @(negedge clk);
    cs_n = 1'b1; wr_n = 1'b1; rd_n = 1'b1;
    #0.5;
    oe_after = data_oe;
    last_rel = 0;
    while (!rdy_n && last_rel < 50) begin
      @(negedge clk);
      last_rel++;
    end
  endtask

  task automatic reg_write(input logic [3:0] a, input logic [7:0] v);
    access(1'b1, 1'b1, {4'h0, a});
    access(1'b0, 1'b1, v);
  endtask

  task automatic reg_read(input logic [3:0] a, output logic [7:0] v);
    access(1'b1, 1'b1, {4'h0, a});
    access(1'b0, 1'b0, 8'h00);
    v = last_dout;
  endtask

  function automatic logic [7:0] pattern(input int a, input int p);
    logic [7:0] v;
    v = 8'((a * 37 + 11) & 255);
    return (p == 0) ? v : ~v;
  endfunction

  function automatic bit writable(input int a);
    return a == 1 || a == 4 || a == 5 || a == 7 || a == 8 || a == 9 || a == 12 || a == 13;
  endfunction

  logic [7:0] shadow [16];

  function automatic logic [7:0] expect_read(input int a);
    if (a == 0) return {shadow[0][7:1], 1'b0};
    if (writable(a)) return shadow[a];
    if (a == 6) return CAM_RD_VAL;
    if (a == 10) return PID_RD_VAL;
    if (a == 15) return REV;
    return 8'h00;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int wc, rc;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk("R1 rdy_n", rdy_n, 1);
    chk("R1 irq_n", irq_n, 1);
    chk("R1 data_oe", data_oe, 0);
    chk("R1 controls", {bus_ctrl, bus_ctrl2, div_a, div_b, ts_en, tuner_rst}, 0);
    chk("R1 addresses", {cam_addr, pid_addr}, 0);
    chk("R1 strobes", {cam_wr, cam_rd, pid_wr, pid_rd, port_wdata}, 0);

    // R3 / R4 / R5 handshake timing on a write and a read
    access(1'b1, 1'b1, 8'h07);
    chk("R3 write latency", last_lat, 3);
    chk("R4 release latency", last_rel, 3);
    chk("R5 no oe on address cycle", last_oe, 0);
    access(1'b0, 1'b0, 8'h00);
    chk("R3 read latency", last_lat, 3);
    chk("R5 oe during read", last_oe, 1);
    chk("R5 oe drops with pins", oe_after, 0);
    access(1'b0, 1'b1, 8'h5E);
    chk("R5 no oe on write", last_oe, 0);

    // R2 address stays latched across data cycles
    access(1'b0, 1'b0, 8'h00);
    chk("R2 read after write", last_dout, 8'h5E);
    access(1'b0, 1'b1, 8'hA1);
    access(1'b0, 1'b0, 8'h00);
    chk("R2 second write same address", last_dout, 8'hA1);
    chk("R2 bus_ctrl output", bus_ctrl, 8'hA1);

    // exhaustive address sweep with two value patterns
    for (int p = 0; p < 2; p++) begin
      wc = cnt_cam_wr;
      rc = cnt_cam_rd;
      for (int a = 0; a < 16; a++) begin
        reg_write(4'(a), pattern(a, p));
        if (a == 0 || writable(a)) shadow[a] = pattern(a, p);
      end
      chk("R11 cam write strobe count", cnt_cam_wr - wc, 1);
      chk("R11 cam write data", last_cam_w, pattern(6, p));
      chk("R11 pid write data", last_pid_w, pattern(10, p));
      for (int a = 0; a < 16; a++) begin
        reg_read(4'(a), v);
        if (writable(a))                      chk("R6 readback", v, expect_read(a));
        else if (a == 15)                     chk("R7 revision", v, expect_read(a));
        else if (a == 6 || a == 10)           chk("R11 port read", v, expect_read(a));
        else if (a == 0)                      chk("R10 ctrl readback", v, expect_read(a));
        else                                  chk("R8 unmapped reads zero", v, expect_read(a));
      end
      chk("R11 cam read strobe count", cnt_cam_rd - rc, 1);
      chk("R6 cam_addr", cam_addr, {shadow[5], shadow[4]});
      chk("R6 pid_addr", pid_addr, {shadow[9], shadow[8]});
      chk("R6 bus_ctrl", bus_ctrl, shadow[7]);
      chk("R6 dividers", {div_a, div_b}, {shadow[12], shadow[13]});
      chk("R9 ts_en", ts_en, shadow[1][5:4]);
      chk("R9 tuner_rst", tuner_rst, shadow[1][3:2]);
    end
    chk("R11 pid strobes", {cnt_pid_wr, cnt_pid_rd}, {32'd2, 32'd2});

    // R9 individual field values
    reg_write(4'h1, 8'h30);
    chk("R9 ts_en both on", {ts_en, tuner_rst}, 4'b1100);
    reg_write(4'h1, 8'h0C);
    chk("R9 tuner_rst both on", {ts_en, tuner_rst}, 4'b0011);

    // R10 interrupt
    reg_write(4'h0, 8'h44);
    @(negedge clk); irq_evt = 1'b1;
    @(negedge clk); irq_evt = 1'b0;
    @(negedge clk);
    chk("R10 irq asserted", irq_n, 0);
    reg_read(4'h0, v);
    chk("R10 pending in bit0", v, 8'h45);
    @(negedge clk);
    chk("R10 irq cleared by read", irq_n, 1);
    reg_read(4'h0, v);
    chk("R10 pending cleared", v, 8'h44);
    reg_write(4'h0, 8'h40);
    @(negedge clk); irq_evt = 1'b1;
    @(negedge clk); irq_evt = 1'b0;
    repeat (3) @(negedge clk);
    chk("R10 irq masked", irq_n, 1);
    reg_read(4'h0, v);
    chk("R10 masked pending visible", v, 8'h41);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule